// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Selectable Error Reactions

This block turns an asynchronous serial line into received words and holds them in a small receive queue. An external oversampling tick, running at sixteen times the bit rate by default, paces the sampler. The sampler confirms each start bit, collects eight or nine data bits with the least significant bit first, checks an optional parity bit, and checks the stop bit. Parity and stop-bit failures set two sticky error flags. Software clears each flag with its own clear pulse.

Four reactions to an error can be switched on separately. The first drops frames that have bad parity. The second switches the receiver off. The third raises a disable line toward the companion transmitter. The fourth holds the DMA request low while an error flag is set. All four reactions are masked while the shared serial unit is in synchronous mode, and the flags still record errors in that mode. A pair read returns the two oldest words together, and a swap control selects which of the two goes in the upper half.

Top module: `async_rx_policy`

## Requirements
- R1: A frame is a low start bit, then 8 data bits (or 9 when `cfg_nine_bit` is 1) sent LSB first, then a parity bit when `cfg_parity_en` is 1, then one stop bit. Each data bit lasts OVERSAMPLE ticks. The stored word carries the data in bits 8:0, and bit 8 is 0 for 8-bit frames.
- R2: A start bit is accepted only if the line is still low half a bit period after the first low sample. A shorter low pulse returns the sampler to idle and stores nothing.
- R3: `par_err_flag` is set when the received parity does not match the configured parity. Even parity applies when `cfg_parity_odd` is 0, odd parity when it is 1. `frm_err_flag` is set when the stop bit sampled at mid-bit is low. Both flags stay set until their clear pulse, and a new error arriving in the same cycle as the clear wins.
- R4: With `cfg_drop_bad_parity` set, a frame with bad parity is not stored, but `par_err_flag` is still set. Frames with good parity are still stored.
- R5: After reset the receiver is off and the queue is empty. With `cfg_err_stop_rx` set, any parity or framing error turns the receiver off. While it is off, line activity stores nothing. Only a `rx_enable_pulse` turns it back on.
- R6: With `cfg_err_stop_tx` set, any receive error raises `tx_disable`, which stays high until `tx_enable_pulse`. With the bit clear, receive errors leave `tx_disable` low.
- R7: `dma_req` is high whenever the queue holds a word. The exception is when `cfg_err_hold_dma` is set and either error flag is set: then `dma_req` is held low.
- R8: When `cfg_sync_mode` is 1, none of the reactions in R4 to R7 take effect, but both error flags are still set.
- R9: The queue holds FIFO_DEPTH words (4 by default) and reports its fill level, full and empty. A word that arrives while the queue is full is dropped, and `fifo_overflow` pulses for one cycle.
- R10: `rd_head` shows the oldest word. A `rd_pop` pulse removes it.
- R11: `rd_pair` holds the oldest word in bits 8:0 and the next word in bits 17:9. When `cfg_pair_swap` is 1, the two halves are exchanged. A `rd_pop_pair` pulse removes both words, and it is ignored when fewer than two words are queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| os_tick | input | 1 | Oversampling tick, OVERSAMPLE per bit |
| rx_in | input | 1 | Serial receive line, idle high |
| cfg_nine_bit | input | 1 | 1 selects 9 data bits |
| cfg_parity_en | input | 1 | 1 adds a parity bit |
| cfg_parity_odd | input | 1 | 1 selects odd parity |
| cfg_sync_mode | input | 1 | 1 masks all error reactions |
| cfg_drop_bad_parity | input | 1 | Drop frames with bad parity |
| cfg_err_stop_rx | input | 1 | Errors switch the receiver off |
| cfg_err_stop_tx | input | 1 | Errors raise tx_disable |
| cfg_err_hold_dma | input | 1 | Error flags hold dma_req low |
| cfg_pair_swap | input | 1 | Exchange the halves of rd_pair |
| rx_enable_pulse | input | 1 | Turns the receiver on |
| tx_enable_pulse | input | 1 | Clears tx_disable |
| clr_par_err | input | 1 | Clears par_err_flag |
| clr_frm_err | input | 1 | Clears frm_err_flag |
| rd_pop | input | 1 | Remove one word |
| rd_pop_pair | input | 1 | Remove two words |
| rd_head | output | 9 | Oldest queued word |
| rd_pair | output | 18 | Two oldest words |
| fifo_level | output | 3 | Number of queued words |
| fifo_full | output | 1 | Queue full |
| fifo_empty | output | 1 | Queue empty |
| fifo_overflow | output | 1 | One-cycle pulse when a word is dropped because the queue is full |
| par_err_flag | output | 1 | Sticky parity error |
| frm_err_flag | output | 1 | Sticky framing error |
| rx_enabled | output | 1 | Receiver is on |
| tx_disable | output | 1 | Disable request to the transmitter |
| dma_req | output | 1 | DMA request |

## Verification
The assertions check, on every cycle, the properties that hold without knowing the line contents. These are: the sticky error flags stay set, the receiver stays off without an enable pulse, `tx_disable` rises only when its reaction is allowed, the DMA hold, the bound on the fill level, and overflow occurring only when the queue is full. Only the bench scenarios can show the rest. That includes correct data and parity decoding for each frame format and rejection of a glitch on the start bit. It also includes dropping bad-parity frames, ignoring the line while the receiver is off, masking of the reactions in synchronous mode, and the word order in normal and swapped pair reads.

// File: rtl/async_rx_pkg.sv
// Shared types for the asynchronous receiver.
// Assumes: frames carry at most nine data bits.
package async_rx_pkg;
    localparam int WORD_W = 9;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP
    } rx_state_e;

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic              par_bad;
        logic              stop_bad;
    } rx_frame_t;
endpackage

// File: rtl/rx_frame_sampler.sv
// Serial frame sampler: synchronises the line, confirms the start bit at
// half a bit period, then samples data, parity and stop bits at mid-bit.
// Assumes: os_tick pulses OVERSAMPLE times per bit; the line idles high.
module rx_frame_sampler
    import async_rx_pkg::*;
#(
    parameter int OVERSAMPLE = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      enable,
    input  logic      os_tick,
    input  logic      rx_in,
    input  logic      nine_bit,
    input  logic      parity_en,
    input  logic      parity_odd,
    output logic      frame_valid,
    output rx_frame_t frame
);
    localparam int CW   = $clog2(OVERSAMPLE);
    localparam int HALF = OVERSAMPLE / 2;

    logic              rx_meta, rx_sync;
    rx_state_e         state;
    logic [CW-1:0]     tick_cnt;
    logic [3:0]        bit_idx;
    logic [WORD_W-1:0] shreg;
    logic              par_bit;
    logic [3:0]        last_idx;
    logic              full_bit, half_bit;

    assign last_idx = nine_bit ? 4'd8 : 4'd7;
    assign full_bit = (tick_cnt == CW'(OVERSAMPLE - 1));
    assign half_bit = (tick_cnt == CW'(HALF - 1));

    // Two-stage synchroniser for the asynchronous line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_meta <= 1'b1;
            rx_sync <= 1'b1;
        end else begin
            rx_meta <= rx_in;
            rx_sync <= rx_meta;
        end
    end

    // Frame state machine paced by the oversampling tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= RX_IDLE;
            tick_cnt    <= '0;
            bit_idx     <= '0;
            shreg       <= '0;
            par_bit     <= 1'b0;
            frame_valid <= 1'b0;
            frame       <= '0;
        end else begin
            frame_valid <= 1'b0;
            if (!enable) begin
                state <= RX_IDLE;
            end else if (os_tick) begin
                case (state)
                    RX_IDLE: begin
                        if (!rx_sync) begin
                            state    <= RX_START;
                            tick_cnt <= '0;
                        end
                    end
                    RX_START: begin
                        if (half_bit) begin
                            tick_cnt <= '0;
                            bit_idx  <= '0;
                            shreg    <= '0;
                            state    <= rx_sync ? RX_IDLE : RX_DATA;
                        end else begin
                            tick_cnt <= tick_cnt + 1'b1;
                        end
                    end
                    RX_DATA: begin
                        if (full_bit) begin
                            tick_cnt       <= '0;
                            shreg[bit_idx] <= rx_sync;
                            if (bit_idx == last_idx) begin
                                state <= parity_en ? RX_PAR : RX_STOP;
                            end else begin
                                bit_idx <= bit_idx + 1'b1;
                            end
                        end else begin
                            tick_cnt <= tick_cnt + 1'b1;
                        end
                    end
                    RX_PAR: begin
                        if (full_bit) begin
                            tick_cnt <= '0;
                            par_bit  <= rx_sync;
                            state    <= RX_STOP;
                        end else begin
                            tick_cnt <= tick_cnt + 1'b1;
                        end
                    end
                    RX_STOP: begin
                        if (full_bit) begin
                            tick_cnt       <= '0;
                            frame_valid    <= 1'b1;
                            frame.data     <= shreg;
                            frame.par_bad  <= parity_en & ((^shreg) ^ par_bit ^ parity_odd);
                            frame.stop_bad <= ~rx_sync;
                            state          <= RX_IDLE;
                        end else begin
                            tick_cnt <= tick_cnt + 1'b1;
                        end
                    end
                    default: state <= RX_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/rx_word_fifo.sv
// Receive word queue with single and pair pops and drop-on-full.
// Assumes: DEPTH is a power of two and at least 2.
module rx_word_fifo #(
    parameter int W     = 9,
    parameter int DEPTH = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [W-1:0]               push_data,
    input  logic                       pop_one,
    input  logic                       pop_two,
    output logic [W-1:0]               head0,
    output logic [W-1:0]               head1,
    output logic [$clog2(DEPTH+1)-1:0] level,
    output logic                       full,
    output logic                       empty,
    output logic                       overflow
);
    localparam int AW   = $clog2(DEPTH);
    localparam int CNTW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] rd_ptr, wr_ptr;
    logic          accept;
    logic [1:0]    pop_n;

    assign full   = (level == CNTW'(DEPTH));
    assign empty  = (level == '0);
    assign accept = push && !full;
    assign head0  = mem[rd_ptr];
    assign head1  = mem[rd_ptr + AW'(1)];

    // Pick how many words leave this cycle; a pair pop wins over a single pop.
    always_comb begin
        if (pop_two && level >= CNTW'(2)) begin
            pop_n = 2'd2;
        end else if (pop_one && !empty) begin
            pop_n = 2'd1;
        end else begin
            pop_n = 2'd0;
        end
    end

    // Storage slots, one register per entry.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem[g] <= '0;
            end else if (accept && wr_ptr == AW'(g)) begin
                mem[g] <= push_data;
            end
        end
    end

    // Pointers, fill level and overflow pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr   <= '0;
            wr_ptr   <= '0;
            level    <= '0;
            overflow <= 1'b0;
        end else begin
            overflow <= push && full;
            if (accept) begin
                wr_ptr <= wr_ptr + 1'b1;
            end
            rd_ptr <= rd_ptr + AW'(pop_n);
            level  <= level + CNTW'(accept) - CNTW'(pop_n);
        end
    end
endmodule

// File: rtl/rx_error_policy.sv
// Error flags and the four selectable reactions to receive errors.
// Assumes: frame_valid is a one-cycle pulse per completed frame.
module rx_error_policy (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_valid,
    input  logic frame_par_bad,
    input  logic frame_stop_bad,
    input  logic sync_mode,
    input  logic drop_bad_parity,
    input  logic err_stop_rx,
    input  logic err_stop_tx,
    input  logic err_hold_dma,
    input  logic clr_par_err,
    input  logic clr_frm_err,
    input  logic rx_enable_pulse,
    input  logic tx_enable_pulse,
    input  logic fifo_empty,
    output logic store_frame,
    output logic par_err_flag,
    output logic frm_err_flag,
    output logic rx_enabled,
    output logic tx_disable,
    output logic dma_req
);
    logic policy_on, new_par, new_frm, any_err;

    assign policy_on   = !sync_mode;
    assign new_par     = frame_valid && frame_par_bad;
    assign new_frm     = frame_valid && frame_stop_bad;
    assign any_err     = new_par || new_frm;
    assign store_frame = frame_valid && !(policy_on && drop_bad_parity && frame_par_bad);
    assign dma_req     = !fifo_empty && !(policy_on && err_hold_dma && (par_err_flag || frm_err_flag));

    // Sticky error flags; a new error beats a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            par_err_flag <= 1'b0;
            frm_err_flag <= 1'b0;
        end else begin
            if (new_par) begin
                par_err_flag <= 1'b1;
            end else if (clr_par_err) begin
                par_err_flag <= 1'b0;
            end
            if (new_frm) begin
                frm_err_flag <= 1'b1;
            end else if (clr_frm_err) begin
                frm_err_flag <= 1'b0;
            end
        end
    end

    // Receiver and transmitter enables driven by the error reactions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_enabled <= 1'b0;
            tx_disable <= 1'b0;
        end else begin
            if (any_err && policy_on && err_stop_rx) begin
                rx_enabled <= 1'b0;
            end else if (rx_enable_pulse) begin
                rx_enabled <= 1'b1;
            end
            if (any_err && policy_on && err_stop_tx) begin
                tx_disable <= 1'b1;
            end else if (tx_enable_pulse) begin
                tx_disable <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/async_rx_policy.sv
// Top of the asynchronous receiver: sampler, error reactions and queue.
// Assumes: all inputs are synchronous to clk except rx_in.
module async_rx_policy
    import async_rx_pkg::*;
#(
    parameter int OVERSAMPLE = 16,
    parameter int FIFO_DEPTH = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            os_tick,
    input  logic                            rx_in,
    input  logic                            cfg_nine_bit,
    input  logic                            cfg_parity_en,
    input  logic                            cfg_parity_odd,
    input  logic                            cfg_sync_mode,
    input  logic                            cfg_drop_bad_parity,
    input  logic                            cfg_err_stop_rx,
    input  logic                            cfg_err_stop_tx,
    input  logic                            cfg_err_hold_dma,
    input  logic                            cfg_pair_swap,
    input  logic                            rx_enable_pulse,
    input  logic                            tx_enable_pulse,
    input  logic                            clr_par_err,
    input  logic                            clr_frm_err,
    input  logic                            rd_pop,
    input  logic                            rd_pop_pair,
    output logic [WORD_W-1:0]               rd_head,
    output logic [2*WORD_W-1:0]             rd_pair,
    output logic [$clog2(FIFO_DEPTH+1)-1:0] fifo_level,
    output logic                            fifo_full,
    output logic                            fifo_empty,
    output logic                            fifo_overflow,
    output logic                            par_err_flag,
    output logic                            frm_err_flag,
    output logic                            rx_enabled,
    output logic                            tx_disable,
    output logic                            dma_req
);
    logic              frame_valid, store_frame;
    rx_frame_t         frame;
    logic [WORD_W-1:0] head1;

    rx_frame_sampler #(.OVERSAMPLE(OVERSAMPLE)) u_sampler (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (rx_enabled),
        .os_tick    (os_tick),
        .rx_in      (rx_in),
        .nine_bit   (cfg_nine_bit),
        .parity_en  (cfg_parity_en),
        .parity_odd (cfg_parity_odd),
        .frame_valid(frame_valid),
        .frame      (frame)
    );

    rx_error_policy u_policy (
        .clk            (clk),
        .rst_n          (rst_n),
        .frame_valid    (frame_valid),
        .frame_par_bad  (frame.par_bad),
        .frame_stop_bad (frame.stop_bad),
        .sync_mode      (cfg_sync_mode),
        .drop_bad_parity(cfg_drop_bad_parity),
        .err_stop_rx    (cfg_err_stop_rx),
        .err_stop_tx    (cfg_err_stop_tx),
        .err_hold_dma   (cfg_err_hold_dma),
        .clr_par_err    (clr_par_err),
        .clr_frm_err    (clr_frm_err),
        .rx_enable_pulse(rx_enable_pulse),
        .tx_enable_pulse(tx_enable_pulse),
        .fifo_empty     (fifo_empty),
        .store_frame    (store_frame),
        .par_err_flag   (par_err_flag),
        .frm_err_flag   (frm_err_flag),
        .rx_enabled     (rx_enabled),
        .tx_disable     (tx_disable),
        .dma_req        (dma_req)
    );

    rx_word_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (store_frame),
        .push_data(frame.data),
        .pop_one  (rd_pop),
        .pop_two  (rd_pop_pair),
        .head0    (rd_head),
        .head1    (head1),
        .level    (fifo_level),
        .full     (fifo_full),
        .empty    (fifo_empty),
        .overflow (fifo_overflow)
    );

    // Pair read: oldest word low unless the swap control is set.
    always_comb begin
        rd_pair = cfg_pair_swap ? {rd_head, head1} : {head1, rd_head};
    end
endmodule

// File: rtl/async_rx_policy_chk.sv
// Cycle-level properties of the receiver, bound to its top module.
module async_rx_policy_chk #(
    parameter int FIFO_DEPTH = 4
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            cfg_sync_mode,
    input logic                            cfg_err_stop_tx,
    input logic                            cfg_err_hold_dma,
    input logic                            rx_enable_pulse,
    input logic                            clr_par_err,
    input logic                            clr_frm_err,
    input logic [$clog2(FIFO_DEPTH+1)-1:0] fifo_level,
    input logic                            fifo_full,
    input logic                            fifo_empty,
    input logic                            fifo_overflow,
    input logic                            par_err_flag,
    input logic                            frm_err_flag,
    input logic                            rx_enabled,
    input logic                            tx_disable,
    input logic                            dma_req
);
    a_r3_par_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (par_err_flag && !clr_par_err) |=> par_err_flag);

    a_r3_frm_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_err_flag && !clr_frm_err) |=> frm_err_flag);

    a_r5_rx_stays_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_enabled && !rx_enable_pulse) |=> !rx_enabled);

    a_r6_tx_needs_policy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_disable) |-> $past(cfg_err_stop_tx && !cfg_sync_mode));

    a_r7_dma_held: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_err_hold_dma && !cfg_sync_mode && (par_err_flag || frm_err_flag)) |-> !dma_req);

    a_r7_dma_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_empty |-> !dma_req);

    a_r9_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_level <= ($clog2(FIFO_DEPTH+1))'(FIFO_DEPTH));

    a_r9_full_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> !fifo_empty);

    a_r9_overflow_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_overflow |-> $past(fifo_full));
endmodule

bind async_rx_policy async_rx_policy_chk #(.FIFO_DEPTH(FIFO_DEPTH)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .cfg_sync_mode   (cfg_sync_mode),
    .cfg_err_stop_tx (cfg_err_stop_tx),
    .cfg_err_hold_dma(cfg_err_hold_dma),
    .rx_enable_pulse (rx_enable_pulse),
    .clr_par_err     (clr_par_err),
    .clr_frm_err     (clr_frm_err),
    .fifo_level      (fifo_level),
    .fifo_full       (fifo_full),
    .fifo_empty      (fifo_empty),
    .fifo_overflow   (fifo_overflow),
    .par_err_flag    (par_err_flag),
    .frm_err_flag    (frm_err_flag),
    .rx_enabled      (rx_enabled),
    .tx_disable      (tx_disable),
    .dma_req         (dma_req)
);

// File: tb/async_rx_policy_test.sv
// Bench: table of frame formats, then directed error-policy and queue tests.
module async_rx_policy_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        os_tick = 1'b1;
    logic        rx_in = 1'b1;
    logic        cfg_nine_bit = 0, cfg_parity_en = 0, cfg_parity_odd = 0;
    logic        cfg_sync_mode = 0, cfg_drop_bad_parity = 0, cfg_err_stop_rx = 0;
    logic        cfg_err_stop_tx = 0, cfg_err_hold_dma = 0, cfg_pair_swap = 0;
    logic        rx_enable_pulse = 0, tx_enable_pulse = 0, clr_par_err = 0, clr_frm_err = 0;
    logic        rd_pop = 0, rd_pop_pair = 0;
    logic [8:0]  rd_head;
    logic [17:0] rd_pair;
    logic [2:0]  fifo_level;
    logic        fifo_full, fifo_empty, fifo_overflow;
    logic        par_err_flag, frm_err_flag, rx_enabled, tx_disable, dma_req;

    int tests = 0;
    int fails = 0;
    logic done = 1'b0;
    logic ovf_seen = 1'b0;

    always #10 clk = ~clk;

    async_rx_policy uut (.*);

    always @(negedge clk) if (fifo_overflow) ovf_seen <= 1'b1;

    // Vector: {nine_bit, parity_en, parity_odd, bad_parity, data[8:0]}
    localparam logic [12:0] VEC [6] = '{
        {1'b0, 1'b0, 1'b0, 1'b0, 9'h0A5},
        {1'b1, 1'b0, 1'b0, 1'b0, 9'h1C3},
        {1'b0, 1'b1, 1'b0, 1'b0, 9'h03C},
        {1'b0, 1'b1, 1'b1, 1'b0, 9'h081},
        {1'b1, 1'b1, 1'b1, 1'b0, 9'h155},
        {1'b0, 1'b1, 1'b0, 1'b1, 9'h077}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic pulse(ref logic sig);
        @(negedge clk);
        sig = 1'b1;
        @(negedge clk);
        sig = 1'b0;
        @(negedge clk);
    endtask

    task automatic hold_line(input logic v, input int cycles);
        rx_in = v;
        repeat (cycles) @(negedge clk);
    endtask

    // Send one frame using the current format inputs.
    task automatic send(input logic [8:0] d, input logic bad_par, input logic stop_v);
        logic [8:0] dm;
        dm = cfg_nine_bit ? d : {1'b0, d[7:0]};
        hold_line(1'b0, 16);
        for (int i = 0; i < (cfg_nine_bit ? 9 : 8); i++) hold_line(dm[i], 16);
        if (cfg_parity_en) hold_line((^dm) ^ cfg_parity_odd ^ bad_par, 16);
        hold_line(stop_v, 16);
        hold_line(1'b1, 24);
    endtask

    task automatic drain();
        while (!fifo_empty) pulse(rd_pop);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R5 reset empty", fifo_empty, 1);
        check("R5 reset rx off", rx_enabled, 0);
        check("R3 reset flags", {par_err_flag, frm_err_flag}, 0);
        check("R6 reset tx", tx_disable, 0);
        check("R7 reset dma", dma_req, 0);

        pulse(rx_enable_pulse);
        check("R5 enable pulse", rx_enabled, 1);

        for (int v = 0; v < 6; v++) begin
            {cfg_nine_bit, cfg_parity_en, cfg_parity_odd} = VEC[v][12:10];
            send(VEC[v][8:0], VEC[v][9], 1'b1);
            check("R9 level one", fifo_level, 1);
            check("R1 data", rd_head, cfg_nine_bit ? VEC[v][8:0] : {1'b0, VEC[v][7:0]});
            check("R3 parity flag", par_err_flag, VEC[v][9]);
            pulse(clr_par_err);
            check("R3 clear", par_err_flag, 0);
            pulse(rd_pop);
            check("R10 pop empties", fifo_empty, 1);
        end
        cfg_nine_bit = 0; cfg_parity_en = 1; cfg_parity_odd = 0;

        // R7: DMA hold on error flags
        send(9'h011, 1'b1, 1'b1);
        check("R7 no hold when off", dma_req, 1);
        cfg_err_hold_dma = 1;
        @(negedge clk);
        check("R7 held by flag", dma_req, 0);
        pulse(clr_par_err);
        check("R7 released", dma_req, 1);
        cfg_err_hold_dma = 0;
        drain();

        // R4: drop bad parity frames
        cfg_drop_bad_parity = 1;
        send(9'h022, 1'b1, 1'b1);
        check("R4 dropped", fifo_level, 0);
        check("R4 flag still set", par_err_flag, 1);
        pulse(clr_par_err);
        send(9'h023, 1'b0, 1'b1);
        check("R4 good kept", rd_head, 9'h023);
        cfg_drop_bad_parity = 0;
        drain();

        // R3: framing error
        send(9'h0C4, 1'b0, 1'b0);
        check("R3 frame flag", frm_err_flag, 1);
        check("R3 frame stored", rd_head, 9'h0C4);
        pulse(clr_frm_err);
        check("R3 frame clear", frm_err_flag, 0);
        drain();

        // R5: stop receiver on error
        cfg_err_stop_rx = 1;
        send(9'h0D1, 1'b0, 1'b0);
        check("R5 rx off", rx_enabled, 0);
        drain();
        pulse(clr_frm_err);
        send(9'h0D2, 1'b0, 1'b1);
        check("R5 ignored while off", fifo_level, 0);
        pulse(rx_enable_pulse);
        check("R5 back on", rx_enabled, 1);
        send(9'h0D3, 1'b0, 1'b1);
        check("R5 receives again", rd_head, 9'h0D3);
        cfg_err_stop_rx = 0;
        drain();

        // R6: transmitter disable
        send(9'h0E1, 1'b1, 1'b1);
        check("R6 no effect when off", tx_disable, 0);
        cfg_err_stop_tx = 1;
        send(9'h0E2, 1'b1, 1'b1);
        check("R6 tx disabled", tx_disable, 1);
        pulse(tx_enable_pulse);
        check("R6 tx reenabled", tx_disable, 0);
        cfg_err_stop_tx = 0;
        pulse(clr_par_err);
        drain();

        // R8: synchronous mode masks the reactions
        cfg_sync_mode = 1; cfg_err_stop_rx = 1; cfg_drop_bad_parity = 1; cfg_err_hold_dma = 1;
        send(9'h0F1, 1'b1, 1'b1);
        check("R8 rx stays on", rx_enabled, 1);
        check("R8 frame kept", fifo_level, 1);
        check("R8 flag set", par_err_flag, 1);
        check("R8 dma not held", dma_req, 1);
        cfg_sync_mode = 0; cfg_err_stop_rx = 0; cfg_drop_bad_parity = 0; cfg_err_hold_dma = 0;
        pulse(clr_par_err);
        drain();

        // R2: short glitch on the line
        hold_line(1'b0, 5);
        hold_line(1'b1, 40);
        check("R2 glitch stores nothing", fifo_level, 0);
        send(9'h05A, 1'b0, 1'b1);
        check("R2 next frame intact", rd_head, 9'h05A);
        drain();

        // R9: overflow
        for (int k = 1; k <= 5; k++) send(9'(k), 1'b0, 1'b1);
        check("R9 full", fifo_full, 1);
        check("R9 level", fifo_level, 4);
        check("R9 overflow pulse", ovf_seen, 1);
        check("R9 oldest kept", rd_head, 9'h001);

        // R11: pair reads
        check("R11 normal order", rd_pair, {9'h002, 9'h001});
        pulse(rd_pop_pair);
        check("R11 pair pop", fifo_level, 2);
        cfg_pair_swap = 1;
        @(negedge clk);
        check("R11 swapped order", rd_pair, {9'h003, 9'h004});
        pulse(rd_pop_pair);
        check("R11 empty after pairs", fifo_empty, 1);
        cfg_pair_swap = 0;
        send(9'h0AA, 1'b0, 1'b1);
        pulse(rd_pop_pair);
        check("R11 pair pop ignored", fifo_level, 1);
        pulse(rd_pop);
        check("R10 final pop", fifo_empty, 1);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule